// File: doc/BRIEF.md
# Mask Before/Including/Only-First Unit

This unit computes a new destination mask from a source mask. It applies one of three rules that are all tied to the lowest-numbered active element whose source bit is 1. The set-before rule sets every active bit that lies below that element. The set-including rule also sets the element itself. The only-first rule sets just that element. Element i of every mask vector is bit i.

An element is active when its index is below `vl` and, with masking enabled, its `v0_mask` bit is 1. Inactive elements and elements at or above `vl` return the prior destination bit unchanged. The caller guarantees that the start index is zero. Overlap checks, illegal-instruction detection and register-file writes are done outside this unit.

A one-cycle `start` strobe samples all inputs. On the following clock edge the unit presents the result on `dst_out` and raises `done` for one cycle. The search for the first set element is a prefix OR over the active set bits. A parameter selects either a log-depth tree or a ripple chain for that prefix.

Top module: `mask_first_unit`

## Requirements
- R1: With `variant` = 2'b00 (set-before), an active result bit is 1 exactly when its source bit is 0 and no lower active element has a source bit of 1.
- R2: With `variant` = 2'b01 (set-including), an active result bit is 1 exactly when no lower active element has a source bit of 1. The first active set element therefore reads 1.
- R3: With `variant` = 2'b10 (only-first), an active result bit is 1 only at the lowest active element whose source bit is 1. At most one active bit is 1.
- R4: A source bit of 1 at an inactive element, or at an element at or above `vl`, does not count as the first set element.
- R5: When `mask_en` = 1, elements below `vl` whose `v0_mask` bit is 0 keep their `old_dst` bit.
- R6: Result bits at indices at or above `vl` keep their `old_dst` bit.
- R7: With `variant` = 2'b11, `dst_out` equals `old_dst`.
- R8: With `vl` = 0, `dst_out` equals `old_dst`, and `done` still pulses.
- R9: Inputs are sampled at the clock edge where `start` = 1. At that same edge `dst_out` takes the result and `done` goes to 1 for exactly one cycle. When `start` = 0, `dst_out` holds its value.
- R10: While `rst_n` = 0 at a clock edge, `dst_out` is cleared to all zeros and `done` to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle strobe that samples all operands |
| variant | input | 2 | 00 set-before, 01 set-including, 10 only-first, 11 keep old |
| mask_en | input | 1 | 1: `v0_mask` gates which elements are active |
| vl | input | $clog2(VLEN+1) | Number of body elements (at most VLEN) |
| src_mask | input | VLEN | Source mask |
| old_dst | input | VLEN | Prior destination mask |
| v0_mask | input | VLEN | Execution mask |
| dst_out | output | VLEN | New destination mask |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
Each rule is run on a single set bit in mid-vector, which separates the before, including and only-first outcomes at that element. Each rule is also run on an all-zero source, where set-before and set-including fill every active bit and only-first clears them. Masked patterns place set bits on inactive elements ahead of the first active set bit, which shows whether inactive bits wrongly trip the flag, and alternating `v0` patterns show that inactive bits keep their old value. Short `vl` values with set bits just beyond `vl`, a zero `vl`, and the keep-old encoding check that tail bits are preserved.

// File: rtl/mfu_pkg.sv
// Shared types for the mask first-element unit.
// Assumes: nothing beyond IEEE 1800-2017.
package mfu_pkg;
    typedef enum logic [1:0] {
        MFU_BEFORE = 2'b00,
        MFU_INCL   = 2'b01,
        MFU_ONLY   = 2'b10,
        MFU_KEEP   = 2'b11
    } mfu_variant_e;
endpackage

// File: rtl/mfu_active_gen.sv
// Builds the per-element active vector. An element is active when its index
// is below vl and, with masking on, its v0 bit is set.
// Assumes: vl <= VLEN.
module mfu_active_gen #(
    parameter int VLEN = 64,
    parameter int VLW  = $clog2(VLEN + 1)
) (
    input  logic [VLW-1:0]  vl,
    input  logic            mask_en,
    input  logic [VLEN-1:0] v0_mask,
    output logic [VLEN-1:0] in_body,
    output logic [VLEN-1:0] active
);
    for (genvar g = 0; g < VLEN; g++) begin : g_el
        // body range test and mask gate for element g
        assign in_body[g] = (VLW'(g) < vl);
        assign active[g]  = in_body[g] & (~mask_en | v0_mask[g]);
    end
endmodule

// File: rtl/mfu_seen_scan.sv
// Exclusive prefix OR: seen[i] is 1 when any hit[j] with j < i is 1.
// TREE = 1 gives a log-depth tree; TREE = 0 gives a ripple chain.
// Assumes: VLEN >= 1.
module mfu_seen_scan #(
    parameter int VLEN = 64,
    parameter bit TREE = 1'b1
) (
    input  logic [VLEN-1:0] hit,
    output logic [VLEN-1:0] seen
);
    localparam int STAGES = (VLEN > 1) ? $clog2(VLEN) : 1;

    logic [VLEN-1:0] incl;

    if (TREE) begin : g_tree
        // log-step doubling OR prefix over the hit vector
        always_comb begin
            logic [VLEN-1:0] cur;
            logic [VLEN-1:0] nxt;
            cur = hit;
            for (int s = 0; s < STAGES; s++) begin
                nxt = cur;
                for (int i = 0; i < VLEN; i++) begin
                    if (i >= (1 << s)) nxt[i] = cur[i] | cur[i - (1 << s)];
                end
                cur = nxt;
            end
            incl = cur;
        end
    end else begin : g_ripple
        assign incl[0] = hit[0];
        for (genvar g = 1; g < VLEN; g++) begin : g_chain
            // ripple the inclusive OR one element per step
            assign incl[g] = incl[g-1] | hit[g];
        end
    end

    if (VLEN > 1) begin : g_shift
        // shift inclusive prefix up by one to make it exclusive
        assign seen = {incl[VLEN-2:0], 1'b0};
    end else begin : g_one
        assign seen = 1'b0;
        logic unused_incl;
        assign unused_incl = incl[0];
    end
endmodule

// File: rtl/mfu_bit_rule.sv
// Per-element result rules for the three variants plus keep-old.
// Inactive elements and keep-old return the prior destination bit.
// Assumes: seen is the exclusive prefix of active set source bits.
module mfu_bit_rule #(
    parameter int VLEN = 64
) (
    input  mfu_pkg::mfu_variant_e variant,
    input  logic [VLEN-1:0]       active,
    input  logic [VLEN-1:0]       src,
    input  logic [VLEN-1:0]       seen,
    input  logic [VLEN-1:0]       old_dst,
    output logic [VLEN-1:0]       result
);
    import mfu_pkg::*;

    for (genvar g = 0; g < VLEN; g++) begin : g_el
        logic rule_bit;
        // choose the per-bit equation for the selected variant
        always_comb begin
            unique case (variant)
                MFU_BEFORE: rule_bit = ~seen[g] & ~src[g];
                MFU_INCL:   rule_bit = ~seen[g];
                MFU_ONLY:   rule_bit = ~seen[g] & src[g];
                default:    rule_bit = old_dst[g];
            endcase
        end
        // keep prior bit on inactive elements
        assign result[g] = active[g] ? rule_bit : old_dst[g];
    end
endmodule

// File: rtl/mask_first_unit.sv
// Top of the mask first-element unit. Samples operands on start, computes
// the new destination mask in one combinational sweep and registers it
// together with a one-cycle done pulse.
// Assumes: vl <= VLEN, start index zero, no operand overlap concerns.
module mask_first_unit #(
    parameter int VLEN      = 64,
    parameter bit SCAN_TREE = 1'b1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         start,
    input  logic [1:0]                   variant,
    input  logic                         mask_en,
    input  logic [$clog2(VLEN+1)-1:0]    vl,
    input  logic [VLEN-1:0]              src_mask,
    input  logic [VLEN-1:0]              old_dst,
    input  logic [VLEN-1:0]              v0_mask,
    output logic [VLEN-1:0]              dst_out,
    output logic                         done
);
    import mfu_pkg::*;

    localparam int VLW = $clog2(VLEN + 1);

    logic [VLEN-1:0] in_body;
    logic [VLEN-1:0] active;
    logic [VLEN-1:0] hit;
    logic [VLEN-1:0] seen;
    logic [VLEN-1:0] result;
    logic [VLEN-1:0] dst_q;
    logic            done_q;

    mfu_active_gen #(.VLEN(VLEN), .VLW(VLW)) u_active (
        .vl      (vl),
        .mask_en (mask_en),
        .v0_mask (v0_mask),
        .in_body (in_body),
        .active  (active)
    );

    // only active source ones may trip the first-seen flag
    assign hit = active & src_mask;

    mfu_seen_scan #(.VLEN(VLEN), .TREE(SCAN_TREE)) u_scan (
        .hit  (hit),
        .seen (seen)
    );

    mfu_bit_rule #(.VLEN(VLEN)) u_rule (
        .variant (mfu_variant_e'(variant)),
        .active  (active),
        .src     (src_mask),
        .seen    (seen),
        .old_dst (old_dst),
        .result  (result)
    );

    logic unused_body;
    assign unused_body = ^in_body;

    // result register loads on start, holds otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) dst_q <= '0;
        else if (start) dst_q <= result;
    end

    // done pulses one cycle after each start
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else done_q <= start;
    end

    assign dst_out = dst_q;
    assign done    = done_q;
endmodule

// File: rtl/mask_first_unit_chk.sv
// Protocol and result checker for mask_first_unit. Captures operands on
// start and checks the registered result on done.
// Assumes: bound into mask_first_unit with matching port names.
module mask_first_unit_chk #(
    parameter int VLEN = 64,
    parameter int VLW  = $clog2(VLEN + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic [1:0]      variant,
    input logic            mask_en,
    input logic [VLW-1:0]  vl,
    input logic [VLEN-1:0] src_mask,
    input logic [VLEN-1:0] old_dst,
    input logic [VLEN-1:0] v0_mask,
    input logic [VLEN-1:0] dst_out,
    input logic            done
);
    logic [1:0]      cap_var;
    logic            cap_en;
    logic [VLW-1:0]  cap_vl;
    logic [VLEN-1:0] cap_src;
    logic [VLEN-1:0] cap_old;
    logic [VLEN-1:0] cap_v0;
    logic [VLEN-1:0] c_body;
    logic [VLEN-1:0] c_act;

    // capture operands at each start
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_var <= '0; cap_en <= 1'b0; cap_vl <= '0;
            cap_src <= '0; cap_old <= '0; cap_v0 <= '0;
        end else if (start) begin
            cap_var <= variant; cap_en <= mask_en; cap_vl <= vl;
            cap_src <= src_mask; cap_old <= old_dst; cap_v0 <= v0_mask;
        end
    end

    // rebuild body and active sets from the captured operands
    always_comb begin
        for (int i = 0; i < VLEN; i++) begin
            c_body[i] = (i < int'(cap_vl));
            c_act[i]  = c_body[i] & (~cap_en | cap_v0[i]);
        end
    end

    assert_done_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);
    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done);
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(dst_out));
    assert_before_clear_on_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_var == 2'b00) |-> ((dst_out & c_act & cap_src) == '0));
    assert_only_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_var == 2'b10) |-> $onehot0(dst_out & c_act));
    assert_inactive_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((dst_out ^ cap_old) & c_body & ~c_act) == '0));
    assert_tail_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (((dst_out ^ cap_old) & ~c_body) == '0));
    assert_keep_variant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_var == 2'b11) |-> (dst_out == cap_old));
    assert_vl_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && cap_vl == '0) |-> (dst_out == cap_old));
    assert_reset_R10: assert property (@(posedge clk)
        !rst_n |=> (dst_out == '0 && !done));
endmodule

bind mask_first_unit mask_first_unit_chk #(.VLEN(VLEN), .VLW(VLW)) u_chk (.*);

// File: tb/mask_first_unit_tb.sv
module mask_first_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int VLEN = 16;
    localparam int VLW  = $clog2(VLEN + 1);
    localparam int NVEC = 14;

    // {variant[71:70], mask_en[69], vl[68:64], src[63:48], old[47:32], v0[31:16], exp[15:0]}
    localparam logic [71:0] VECS [NVEC] = '{
        {2'd0, 1'b0, 5'd16, 16'h0010, 16'h0000, 16'h0000, 16'h000F}, // R1 single bit
        {2'd1, 1'b0, 5'd16, 16'h0010, 16'h0000, 16'h0000, 16'h001F}, // R2 single bit
        {2'd2, 1'b0, 5'd16, 16'h0010, 16'h0000, 16'h0000, 16'h0010}, // R3 single bit
        {2'd0, 1'b0, 5'd16, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF}, // R1 zero source
        {2'd1, 1'b0, 5'd16, 16'h0000, 16'h0000, 16'h0000, 16'hFFFF}, // R2 zero source
        {2'd2, 1'b0, 5'd8,  16'h0300, 16'hF0F0, 16'h0000, 16'hF000}, // R6 set bits past vl
        {2'd0, 1'b1, 5'd16, 16'h0045, 16'h000A, 16'hFFF0, 16'h003A}, // R4 masked set bits
        {2'd1, 1'b1, 5'd16, 16'h0045, 16'h000A, 16'hFFF0, 16'h007A}, // R4 including
        {2'd2, 1'b1, 5'd16, 16'h0045, 16'h000A, 16'hFFF0, 16'h004A}, // R4 only-first
        {2'd3, 1'b0, 5'd16, 16'h1234, 16'h5A5A, 16'h0000, 16'h5A5A}, // R7 keep
        {2'd0, 1'b0, 5'd0,  16'h0000, 16'h1357, 16'h0000, 16'h1357}, // R8 vl zero
        {2'd1, 1'b1, 5'd12, 16'h0F00, 16'hC3C3, 16'h00FF, 16'hC3FF}, // R5 inactive set bits
        {2'd2, 1'b1, 5'd16, 16'h0006, 16'h5555, 16'hAAAA, 16'h5557}, // R5 alternating v0
        {2'd0, 1'b0, 5'd5,  16'h0001, 16'hFFFF, 16'h0000, 16'hFFE0}  // R6 short vl
    };
    localparam string TAGS [NVEC] = '{"R1", "R2", "R3", "R1", "R2", "R6", "R4",
                                      "R4", "R4", "R7", "R8", "R5", "R5", "R6"};

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [1:0]      variant = '0;
    logic            mask_en = 1'b0;
    logic [VLW-1:0]  vl = '0;
    logic [VLEN-1:0] src_mask = '0;
    logic [VLEN-1:0] old_dst = '0;
    logic [VLEN-1:0] v0_mask = '0;
    logic [VLEN-1:0] dst_out;
    logic            done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mask_first_unit #(.VLEN(VLEN)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .variant(variant),
        .mask_en(mask_en), .vl(vl), .src_mask(src_mask), .old_dst(old_dst),
        .v0_mask(v0_mask), .dst_out(dst_out), .done(done)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // issue one start with given operands; returns after the result edge
    task automatic issue(input logic [71:0] v);
        @(negedge clk);
        variant = v[71:70]; mask_en = v[69]; vl = v[68:64];
        src_mask = v[63:48]; old_dst = v[47:32]; v0_mask = v[31:16];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset dst", 32'(dst_out), 32'h0);
        check("R10 reset done", 32'(done), 32'h0);
        rst_n = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            issue(VECS[k]);
            check(TAGS[k], 32'(dst_out), 32'(VECS[k][15:0]));
            check("R9 done pulse", 32'(done), 32'h1);
        end

        // R9: done drops and dst holds while operands change without start
        @(negedge clk);
        src_mask = 16'hFFFF; old_dst = 16'h0000; variant = 2'd1;
        check("R9 done single", 32'(done), 32'h0);
        @(negedge clk);
        check("R9 hold", 32'(dst_out), 32'hFFE0);

        // R8: vl zero still pulses done
        issue({2'd2, 1'b0, 5'd0, 16'hFFFF, 16'hABCD, 16'h0000, 16'h0000});
        check("R8 done", 32'(done), 32'h1);
        check("R8 dst", 32'(dst_out), 32'hABCD);

        // R4: first active set bit is the last element when others are masked
        issue({2'd2, 1'b1, 5'd16, 16'hFFFF, 16'h0000, 16'h8000, 16'h0000});
        check("R4 last element", 32'(dst_out), 32'h8000);

        // R10: reset mid-run clears outputs
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reclear", 32'(dst_out), 32'h0);
        rst_n = 1'b1;

        finished = 1'b1;
    end

    initial begin
        fork
            wait (finished);
            begin
                repeat (5000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule